// File: doc/BRIEF.md
# Selectable Trigger Source with Busy Veto

This block generates trigger candidates from up to three sources, each switched on by its own bit of a source-select word. The sources are an external trigger pin, a built-in pulser with a programmable period, and a built-in random pulser whose firing probability per clock is set by a 32-bit threshold. A candidate is declared in any clock where at least one enabled source fires. The external pin is edge-detected, so a long high level gives a single candidate.

Each channel has a busy line. A mask chooses which busy lines count. The masked lines are ORed into one veto. A candidate becomes an accepted trigger only when that veto is low and the run-enable bit of the control word is set. Accepted triggers are fanned out to an output vector, and each bit of that vector is gated by its own output-mask bit.

The raw busy state and the combined veto are presented as registered status. The period pulser is a two-state machine. In `PUL_OFF` its counter is held at zero. The transition `go` (pulser selected and period non-zero) enters `PUL_RUN`, where the counter advances and fires on its last count. The transition `stop` (pulser deselected or period zero) returns it to `PUL_OFF`.

Top module: `trig_gen`

## Requirements
- R1: After reset, `ctrl_q` reads 16'h8000 (run enable on, soft spill off), and `cand_o`, `acc_o`, `trig_out` and `veto_o` are all zero.
- R2: A write to the control word stores only bit 15 (run enable) and bit 14 (soft spill enable). Every other bit reads back as zero on the next cycle.
- R3: With `src_sel` bit 0 set, a rising edge on `ext_trig` gives a `cand_o` pulse exactly one clock long, in the cycle after the edge. A level held high gives no further candidate. With bit 0 clear, `ext_trig` gives no candidate.
- R4: With `src_sel` bit 15 set and `fix_period` = P > 0, candidates repeat every P clocks. With P = 1 they occur on every clock.
- R5: A `fix_period` of zero stops the period pulser completely.
- R6: With `src_sel` bit 14 set, the random pulser fires in a clock when a free-running non-zero 32-bit LFSR value is below `rnd_prob`. A value of 0 never fires. A value of all ones fires on almost every clock. Intermediate values fire in proportion to the value.
- R7: `acc_o` is high in the same cycle as `cand_o` when no masked busy line was high and run enable was set in the clock that produced the candidate.
- R8: A busy line whose `xoff_mask` bit is 0 has no effect on acceptance or on `veto_o`.
- R9: With run enable (control bit 15) clear, candidates still appear but none is accepted.
- R10: `trig_out` equals `out_mask` in each cycle where `acc_o` is high, and is zero otherwise.
- R11: `xoff_state_o` shows the raw `xoff_in` and `veto_o` shows the OR of the masked busy lines, both one clock late and whatever the mask is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_q | output | 16 | Control word readback |
| src_sel | input | 16 | Source select: bit 0 external, bit 14 random, bit 15 period pulser |
| fix_period | input | 32 | Period pulser interval in clocks; 0 disables |
| rnd_prob | input | 32 | Random pulser threshold per clock |
| ext_trig | input | 1 | External trigger input |
| xoff_in | input | NCH | Per-channel busy lines |
| xoff_mask | input | NCH | Busy lines taking part in the veto |
| out_mask | input | NOUT | Per-output gate for accepted triggers |
| cand_o | output | 1 | Trigger candidate strobe |
| acc_o | output | 1 | Accepted trigger strobe |
| trig_out | output | NOUT | Masked accepted-trigger outputs |
| xoff_state_o | output | NCH | Registered raw busy lines |
| veto_o | output | 1 | Registered combined veto |

## Verification
The bench holds the external pin high for several clocks. A design that fed the level, not the edge, would give a train of candidates. It sets a period of one and then zero. An off-by-one terminal count would skip clocks or still fire at zero. It sets a busy line with its mask bit off and then on. A design that ignored the mask, or sampled the veto a clock late, would accept the wrong candidate. It clears run enable and sets probabilities of zero, all ones and one quarter. A comparator of the wrong sense or width would fire when it should stay silent, or at the wrong rate.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int SEL_EXT    = 0;
    localparam int SEL_RND    = 14;
    localparam int SEL_FIX    = 15;
    localparam int CTRL_RUN   = 15;
    localparam int CTRL_SPILL = 14;
    localparam logic [15:0] CTRL_RESET = 16'h8000;
    localparam logic [15:0] CTRL_KEEP  = 16'hC000;

    typedef enum logic [0:0] {
        PUL_OFF = 1'b0,
        PUL_RUN = 1'b1
    } pul_state_t;
endpackage

// File: rtl/trig_fix_pulser.sv
module trig_fix_pulser
    import trig_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] period,
    output logic         fire
);
    pul_state_t   state_q, state_nx;
    logic [W-1:0] cnt_q;
    logic         go;
    logic         at_end;

    assign go     = en && (period != '0);
    assign at_end = (cnt_q >= period - W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PUL_OFF;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PUL_OFF: if (go)  state_nx = PUL_RUN;
            PUL_RUN: if (!go) state_nx = PUL_OFF;
            default: state_nx = PUL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (state_q == PUL_RUN && go)    cnt_q <= at_end ? '0 : cnt_q + W'(1);
        else                                  cnt_q <= '0;
    end

    assign fire = (state_q == PUL_RUN) && go && at_end;

    AST_OFF_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PUL_OFF) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/trig_rnd_pulser.sv
module trig_rnd_pulser #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] prob,
    output logic         fire
);
    logic [W-1:0] lfsr_q;
    logic [W-1:0] shifted;

    assign shifted = lfsr_q >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n)         lfsr_q <= SEED;
        else if (lfsr_q[0]) lfsr_q <= shifted ^ TAPS;
        else                lfsr_q <= shifted;
    end

    assign fire = en && (lfsr_q < prob);

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R6
endmodule

// File: rtl/trig_veto.sv
module trig_veto #(
    parameter int NCH = 14
) (
    input  logic [NCH-1:0] xoff,
    input  logic [NCH-1:0] mask,
    output logic           veto
);
    logic [NCH-1:0] masked;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign masked[i] = xoff[i] & mask[i];
    end

    assign veto = |masked;
endmodule

// File: rtl/trig_gen.sv
module trig_gen
    import trig_pkg::*;
#(
    parameter int NCH  = 14,
    parameter int NOUT = 16,
    parameter int PW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_we,
    input  logic [15:0]     ctrl_wdata,
    output logic [15:0]     ctrl_q,
    input  logic [15:0]     src_sel,
    input  logic [PW-1:0]   fix_period,
    input  logic [PW-1:0]   rnd_prob,
    input  logic            ext_trig,
    input  logic [NCH-1:0]  xoff_in,
    input  logic [NCH-1:0]  xoff_mask,
    input  logic [NOUT-1:0] out_mask,
    output logic            cand_o,
    output logic            acc_o,
    output logic [NOUT-1:0] trig_out,
    output logic [NCH-1:0]  xoff_state_o,
    output logic            veto_o
);
    logic ext_q;
    logic ext_edge;
    logic fix_fire;
    logic rnd_fire;
    logic veto_now;
    logic cand_nx;
    logic acc_nx;

    trig_fix_pulser #(.W(PW)) i_fix (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (src_sel[SEL_FIX]),
        .period(fix_period),
        .fire  (fix_fire)
    );

    trig_rnd_pulser #(.W(PW)) i_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (src_sel[SEL_RND]),
        .prob  (rnd_prob),
        .fire  (rnd_fire)
    );

    trig_veto #(.NCH(NCH)) i_veto (
        .xoff (xoff_in),
        .mask (xoff_mask),
        .veto (veto_now)
    );

    assign ext_edge = ext_trig & ~ext_q;
    assign cand_nx  = (src_sel[SEL_EXT] & ext_edge) | fix_fire | rnd_fire;
    assign acc_nx   = cand_nx & ~veto_now & ctrl_q[CTRL_RUN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= CTRL_RESET;
            ext_q        <= 1'b0;
            cand_o       <= 1'b0;
            acc_o        <= 1'b0;
            trig_out     <= '0;
            xoff_state_o <= '0;
            veto_o       <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_KEEP;
            ext_q        <= ext_trig;
            cand_o       <= cand_nx;
            acc_o        <= acc_nx;
            trig_out     <= acc_nx ? out_mask : '0;
            xoff_state_o <= xoff_in;
            veto_o       <= veto_now;
        end
    end

    AST_ACC_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> cand_o); // R7
    AST_ACC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_o) |-> (!$past(veto_now) && $past(ctrl_q[CTRL_RUN]))); // R9
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_out) |-> acc_o); // R10
    AST_PERIOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_period == '0 && src_sel == 16'h8000) |=> !cand_o); // R5
    AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == 16'h0); // R2
endmodule

// File: tb/test_trig_gen.sv
module test_trig_gen;
    localparam int NCH = 14;
    localparam int NOUT = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctrl_we = 1'b0;
    logic [15:0]     ctrl_wdata = '0;
    logic [15:0]     ctrl_q;
    logic [15:0]     src_sel = '0;
    logic [31:0]     fix_period = '0;
    logic [31:0]     rnd_prob = '0;
    logic            ext_trig = 1'b0;
    logic [NCH-1:0]  xoff_in = '0;
    logic [NCH-1:0]  xoff_mask = '0;
    logic [NOUT-1:0] out_mask = '0;
    logic            cand_o, acc_o, veto_o;
    logic [NOUT-1:0] trig_out;
    logic [NCH-1:0]  xoff_state_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trig_gen #(.NCH(NCH), .NOUT(NOUT)) i_trig_gen (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .src_sel(src_sel), .fix_period(fix_period),
        .rnd_prob(rnd_prob), .ext_trig(ext_trig), .xoff_in(xoff_in),
        .xoff_mask(xoff_mask), .out_mask(out_mask), .cand_o(cand_o),
        .acc_o(acc_o), .trig_out(trig_out), .xoff_state_o(xoff_state_o),
        .veto_o(veto_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic t_reset;
        tick(3);
        rst_n = 1'b1;
        tick();
        chk(ctrl_q == 16'h8000, "R1 ctrl reset", ctrl_q, 16'h8000);
        chk(!cand_o && !acc_o, "R1 strobes idle", {cand_o, acc_o}, 0);
        chk(trig_out == 0 && !veto_o, "R1 outputs idle", trig_out, 0);
    endtask

    task automatic t_ctrl;
        wr_ctrl(16'h7FFF);
        chk(ctrl_q == 16'h4000, "R2 reserved bits dropped", ctrl_q, 16'h4000);
        wr_ctrl(16'hFFFF);
        chk(ctrl_q == 16'hC000, "R2 both bits set", ctrl_q, 16'hC000);
        wr_ctrl(16'h8000);
    endtask

    task automatic t_ext;
        src_sel = 16'h0001;
        ext_trig = 1'b1;
        tick();
        chk(cand_o == 1'b1, "R3 edge gives candidate", cand_o, 1);
        chk(acc_o == 1'b1, "R7 clean candidate accepted", acc_o, 1);
        tick();
        chk(cand_o == 1'b0, "R3 one clock only", cand_o, 0);
        tick(2);
        chk(cand_o == 1'b0, "R3 held level silent", cand_o, 0);
        ext_trig = 1'b0;
        tick(2);
        src_sel = 16'h0000;
        ext_trig = 1'b1;
        tick();
        chk(cand_o == 1'b0, "R3 source deselected", cand_o, 0);
        ext_trig = 1'b0;
        tick(2);
    endtask

    task automatic t_veto;
        src_sel = 16'h0001;
        out_mask = 16'h00F0;
        xoff_in = 14'h0008;
        xoff_mask = 14'h0000;
        tick();
        chk(veto_o == 1'b0, "R8 unmasked busy no veto", veto_o, 0);
        chk(xoff_state_o == 14'h0008, "R11 raw busy shown", xoff_state_o, 14'h0008);
        ext_trig = 1'b1;
        tick();
        chk(acc_o == 1'b1, "R8 unmasked busy ignored", acc_o, 1);
        chk(trig_out == 16'h00F0, "R10 masked outputs", trig_out, 16'h00F0);
        ext_trig = 1'b0;
        tick();
        chk(trig_out == 16'h0000, "R10 outputs drop", trig_out, 0);
        xoff_mask = 14'h0008;
        tick();
        chk(veto_o == 1'b1, "R11 combined veto", veto_o, 1);
        ext_trig = 1'b1;
        tick();
        chk(cand_o == 1'b1 && acc_o == 1'b0, "R7 vetoed candidate", {cand_o, acc_o}, 2'b10);
        chk(trig_out == 16'h0000, "R10 vetoed outputs", trig_out, 0);
        ext_trig = 1'b0;
        xoff_in = '0;
        xoff_mask = '0;
        tick(2);
        src_sel = '0;
    endtask

    task automatic t_run_off;
        src_sel = 16'h0001;
        wr_ctrl(16'h0000);
        ext_trig = 1'b1;
        tick();
        chk(cand_o == 1'b1 && acc_o == 1'b0, "R9 run off blocks accept", {cand_o, acc_o}, 2'b10);
        ext_trig = 1'b0;
        wr_ctrl(16'h8000);
        tick();
        src_sel = '0;
    endtask

    task automatic t_fixed;
        int last;
        int cnt;
        bit gap_ok;
        fix_period = 32'd5;
        src_sel = 16'h8000;
        last = -1; cnt = 0; gap_ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (cand_o) begin
                if (last >= 0 && (i - last) != 5) gap_ok = 1'b0;
                last = i;
                cnt++;
            end
        end
        chk(gap_ok, "R4 interval of five", gap_ok, 1);
        chk(cnt >= 11 && cnt <= 12, "R4 pulse count", cnt, 12);
        fix_period = 32'd1;
        tick(3);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (cand_o) cnt++;
        end
        chk(cnt == 10, "R4 period one every clock", cnt, 10);
        fix_period = 32'd0;
        tick(2);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (cand_o) cnt++;
        end
        chk(cnt == 0, "R5 period zero silent", cnt, 0);
        src_sel = '0;
        tick(2);
    endtask

    task automatic t_random;
        int cnt;
        src_sel = 16'h4000;
        rnd_prob = 32'h0;
        tick(2);
        cnt = 0;
        for (int i = 0; i < 500; i++) begin
            tick();
            if (cand_o) cnt++;
        end
        chk(cnt == 0, "R6 zero probability", cnt, 0);
        rnd_prob = 32'hFFFF_FFFF;
        tick(2);
        cnt = 0;
        for (int i = 0; i < 500; i++) begin
            tick();
            if (cand_o) cnt++;
        end
        chk(cnt >= 499, "R6 full probability", cnt, 500);
        rnd_prob = 32'h4000_0000;
        tick(2);
        cnt = 0;
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (cand_o) cnt++;
        end
        chk(cnt >= 300 && cnt <= 700, "R6 quarter probability", cnt, 500);
        src_sel = '0;
        rnd_prob = '0;
        tick(2);
    endtask

    initial begin
        t_reset();
        t_ctrl();
        t_ext();
        t_veto();
        t_run_off();
        t_fixed();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule